// File: doc/BRIEF.md
# Asynchronous Bus Read Requester

This block is the device end of a four-phase, unclocked read from a memory that sits on a shared, bidirectional data bus. A local client pulses `start_i` with an address. The block puts that address on the bus, raises its read request and waits for the memory's acknowledge. It then releases the bus and waits for the acknowledge to fall again. Next it waits for the memory's data-ready strobe, takes the returned word off the same bus lines and acknowledges it. When the strobe falls it drops its own acknowledge and reports completion.

The memory runs on no clock shared with this block. Both incoming control lines therefore go through multi-flop synchronizers before the state machine acts on them. The returned word is sampled straight from the bus. This is safe because the memory keeps it stable from before it raises the strobe until it sees the device acknowledge. The device's bus drive is given as a value plus a separate enable. The enclosing design merges that pair with the memory's drive onto the physical lines.

Top module: `abus_read_req`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `read_req_o`, `bus_oe_o`, `dev_ack_o` and `done_o` are 0 and `data_o` is all zeros.
- R2: A `start_i` pulse seen while the block is idle makes `read_req_o` and `bus_oe_o` go high at the next clock edge. From that edge `bus_out_o` carries the `addr_i` value sampled with the pulse and holds it while `read_req_o` is high.
- R3: `bus_oe_o` is high only while `read_req_o` is high. Both fall together, only after `mem_ack_i` has been high for at least two consecutive clocks. `bus_oe_o` is never high together with `dev_ack_o`.
- R4: `dev_ack_o` does not rise while the memory's acknowledge of the address phase is still high. The block waits for `mem_ack_i` to be seen low before it looks at `data_rdy_i`.
- R5: Once `data_rdy_i` has been high for at least two clocks, the block samples `bus_in_i` into `data_o` and raises `dev_ack_o` at the same edge. `data_o` changes at no other time.
- R6: After `data_rdy_i` is seen low, `dev_ack_o` falls and `done_o` is high for exactly one clock, in the first cycle with `dev_ack_o` low. `data_o` then holds the captured word until the next capture.
- R7: `start_i` pulses that arrive while a transaction is in progress are ignored. No extra bus request is made and the address on the bus does not change.
- R8: A `start_i` pulse in the same cycle as `done_o` is accepted and begins the next read at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a read (accepted only when idle) |
| addr_i | input | W | Read address, sampled with an accepted start |
| done_o | output | 1 | One-cycle completion pulse |
| data_o | output | W | Word returned by the last completed read |
| read_req_o | output | 1 | Read request line to memory |
| bus_out_o | output | W | Value the device drives on the shared data lines |
| bus_oe_o | output | 1 | Enable for the device's drive of the data lines |
| bus_in_i | input | W | Current state of the shared data lines |
| mem_ack_i | input | 1 | Acknowledge from memory (address phase) |
| data_rdy_i | input | 1 | Data-ready strobe from memory |
| dev_ack_o | output | 1 | Device acknowledge of returned data |

## Verification
Completion reporting and request acceptance can fall in the same cycle. The idle state is entered at the edge that raises `done_o`, so a start that arrives during the done pulse must open a new read without disturbing the word just reported. The bench waits for `done_o` and raises `start_i` in that very cycle, three times in a chain. It judges the outcome in three ways. A bus request and the new address must appear on the next edge. The scoreboard must receive each word in order. The memory model must record every address exactly once.

// File: rtl/abus_rd_pkg.sv
// Shared definitions for the asynchronous bus read requester.
// Assumes nothing beyond standard SystemVerilog packages.
package abus_rd_pkg;

    // Transaction phases, in the order a read walks through them.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,  // waiting for a local start
        PH_ADDR  = 3'd1,  // address on bus, request high
        PH_ACKLO = 3'd2,  // waiting for memory acknowledge to clear
        PH_WAITD = 3'd3,  // waiting for data-ready strobe
        PH_HOLD  = 3'd4   // data taken, device acknowledge high
    } rd_phase_e;

endpackage

// File: rtl/abus_sync.sv
// Multi-flop synchronizer for a group of independent single-bit lines.
// Assumes each bit is a level that stays put for longer than STAGES clocks;
// bits are not guaranteed to arrive in the same cycle as one another.
module abus_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Shift the raw levels through the flop chain; reset clears every stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign sync_o = chain_q[LAST];

endmodule

// File: rtl/abus_rd_fsm.sv
// Phase controller for the four-phase read. Consumes synchronized control
// lines only and produces Moore-style bus controls plus load strobes for
// the address and data registers in the top level.
// Assumes ack_s and rdy_s are already synchronous to clk.
module abus_rd_fsm
    import abus_rd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic ack_s,
    input  logic rdy_s,
    output logic req_o,
    output logic oe_o,
    output logic dev_ack_o,
    output logic load_addr_o,
    output logic load_data_o,
    output logic done_o
);

    rd_phase_e phase_q, phase_d;
    logic      done_q;

    // Next-phase selection: each phase waits on one condition.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:  if (start_i) phase_d = PH_ADDR;
            PH_ADDR:  if (ack_s)   phase_d = PH_ACKLO;
            PH_ACKLO: if (!ack_s)  phase_d = PH_WAITD;
            PH_WAITD: if (rdy_s)   phase_d = PH_HOLD;
            PH_HOLD:  if (!rdy_s)  phase_d = PH_IDLE;
            default:               phase_d = PH_IDLE;
        endcase
    end

    // Phase register and registered completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            done_q  <= (phase_q == PH_HOLD) && !rdy_s;
        end
    end

    assign req_o       = (phase_q == PH_ADDR);
    assign oe_o        = (phase_q == PH_ADDR);
    assign dev_ack_o   = (phase_q == PH_HOLD);
    assign load_addr_o = (phase_q == PH_IDLE) && start_i;
    assign load_data_o = (phase_q == PH_WAITD) && rdy_s;
    assign done_o      = done_q;

endmodule

// File: rtl/abus_read_req.sv
// Device side of an asynchronous four-phase bus read. Synchronizes the
// memory's acknowledge and data-ready lines, sequences request/release/
// capture/acknowledge, and reports the captured word with a done pulse.
// Assumes the memory holds the data lines stable from before it raises
// data-ready until it observes the device acknowledge.
module abus_read_req #(
    parameter int W          = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] addr_i,
    output logic         done_o,
    output logic [W-1:0] data_o,
    output logic         read_req_o,
    output logic [W-1:0] bus_out_o,
    output logic         bus_oe_o,
    input  logic [W-1:0] bus_in_i,
    input  logic         mem_ack_i,
    input  logic         data_rdy_i,
    output logic         dev_ack_o
);

    localparam int NCTL = 2;

    logic [NCTL-1:0] ctl_raw, ctl_s;
    logic            load_addr, load_data;
    logic [W-1:0]    addr_q, data_q;

    assign ctl_raw = {data_rdy_i, mem_ack_i};

    abus_sync #(.WIDTH(NCTL), .STAGES(SYNC_DEPTH)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ctl_raw),
        .sync_o  (ctl_s)
    );

    abus_rd_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .ack_s       (ctl_s[0]),
        .rdy_s       (ctl_s[1]),
        .req_o       (read_req_o),
        .oe_o        (bus_oe_o),
        .dev_ack_o   (dev_ack_o),
        .load_addr_o (load_addr),
        .load_data_o (load_data),
        .done_o      (done_o)
    );

    // Address and returned-data holding registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (load_addr) addr_q <= addr_i;
            if (load_data) data_q <= bus_in_i;
        end
    end

    assign bus_out_o = addr_q;
    assign data_o    = data_q;

endmodule

// File: rtl/abus_read_req_chk.sv
// Protocol checker for abus_read_req, attached to every instance by bind.
// Assumes a synchronizer depth of at least two.
module abus_read_req_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         mem_ack_i,
    input logic         data_rdy_i,
    input logic         read_req_o,
    input logic         bus_oe_o,
    input logic [W-1:0] bus_out_o,
    input logic         dev_ack_o,
    input logic         done_o,
    input logic [W-1:0] data_o
);

    assert_addr_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (read_req_o && $past(read_req_o)) |-> $stable(bus_out_o));

    assert_oe_with_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe_o |-> read_req_o);

    assert_release_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(read_req_o) |-> ($past(mem_ack_i) && $past(mem_ack_i, 2)));

    assert_no_drive_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_oe_o && dev_ack_o));

    assert_ack_needs_rdy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_ack_o) |-> ($past(data_rdy_i) && $past(data_rdy_i, 2)));

    assert_capture_only_on_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_o) |-> $rose(dev_ack_o));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!dev_ack_o && $past(dev_ack_o)));

    assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_ack_o && start_i) |=> !read_req_o);

endmodule

bind abus_read_req abus_read_req_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .mem_ack_i  (mem_ack_i),
    .data_rdy_i (data_rdy_i),
    .read_req_o (read_req_o),
    .bus_oe_o   (bus_oe_o),
    .bus_out_o  (bus_out_o),
    .dev_ack_o  (dev_ack_o),
    .done_o     (done_o),
    .data_o     (data_o)
);

// File: tb/abus_read_req_tb.sv
`timescale 1ns/100ps
// Scoreboard bench: the driver queues expected words, a monitor compares
// them on each done pulse, and a memory model on its own clock answers.
module abus_read_req_tb;

    localparam int W = 16;
    localparam logic [W-1:0] KEY = 16'h5A3C;

    logic         clk = 1'b0, clk_m = 1'b0, rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [W-1:0] addr_i = '0;
    logic         done_o, read_req_o, bus_oe_o, dev_ack_o;
    logic [W-1:0] data_o, bus_out_o, bus_in_i;
    logic         mem_ack = 1'b0, mem_rdy = 1'b0, mem_oe = 1'b0;
    logic [W-1:0] mem_data = '0;

    int n_chk = 0, n_fail = 0, n_done = 0;
    bit finished = 0;
    logic [W-1:0] exp_q[$];
    logic [W-1:0] issued_q[$];
    logic [W-1:0] seen_q[$];

    always #4 clk = ~clk;          // 125 MHz
    always #5.5 clk_m = ~clk_m;    // memory's unrelated clock

    assign bus_in_i = bus_oe_o ? bus_out_o : (mem_oe ? mem_data : '0);

    abus_read_req #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .done_o(done_o), .data_o(data_o), .read_req_o(read_req_o),
        .bus_out_o(bus_out_o), .bus_oe_o(bus_oe_o), .bus_in_i(bus_in_i),
        .mem_ack_i(mem_ack), .data_rdy_i(mem_rdy), .dev_ack_o(dev_ack_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory model: latch address, ack, wait release, return data, wait ack.
    initial begin
        forever begin
            @(posedge clk_m);
            if (rst_n && read_req_o && !mem_ack) begin
                logic [W-1:0] a;
                int lat;
                a = bus_in_i;
                seen_q.push_back(a);
                chk(bus_oe_o === 1'b1, "R3 oe high with request", {15'd0, bus_oe_o}, 1);
                lat = int'(a[1:0]) + 1;
                mem_ack <= 1'b1;
                do @(posedge clk_m); while (read_req_o);
                mem_ack <= 1'b0;
                repeat (lat) @(posedge clk_m);
                chk(bus_oe_o === 1'b0, "R3 device off bus before memory drive", {15'd0, bus_oe_o}, 0);
                mem_data <= a ^ KEY;
                mem_oe   <= 1'b1;
                @(posedge clk_m);
                mem_rdy <= 1'b1;
                do @(posedge clk_m); while (!dev_ack_o);
                mem_oe  <= 1'b0;
                mem_rdy <= 1'b0;
                do @(posedge clk_m); while (dev_ack_o);
            end
        end
    end

    // Monitor: scoreboard compare on done, one-cycle width, R4 ordering.
    logic         prev_ack = 1'b0, prev_done = 1'b0;
    logic [W-1:0] held = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (dev_ack_o && !prev_ack)
                chk(mem_ack === 1'b0, "R4 dev ack while memory ack high", {15'd0, mem_ack}, 0);
            if (done_o) begin
                n_done++;
                chk(dev_ack_o === 1'b0, "R6 ack low at done", {15'd0, dev_ack_o}, 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected completion", data_o, '0);
                end else begin
                    logic [W-1:0] e;
                    e = exp_q.pop_front();
                    chk(data_o === e, "R5 captured data", data_o, e);
                end
                held = data_o;
            end
            if (prev_done) begin
                chk(done_o === 1'b0, "R6 done lasts one cycle", {15'd0, done_o}, 0);
                chk(data_o === held, "R6 data held after done", data_o, held);
            end
        end
        prev_ack  = dev_ack_o;
        prev_done = done_o;
    end

    task automatic issue(input logic [W-1:0] a, input bit busy_poke, input string tag);
        start_i = 1'b1;
        addr_i  = a;
        exp_q.push_back(a ^ KEY);
        issued_q.push_back(a);
        @(negedge clk);
        start_i = 1'b0;
        addr_i  = ~a;
        chk(read_req_o === 1'b1, {tag, " request raised"}, {15'd0, read_req_o}, 1);
        chk(bus_out_o === a, {tag, " address on bus"}, bus_out_o, a);
        if (busy_poke) begin
            repeat (3) @(negedge clk);
            start_i = 1'b1;
            addr_i  = 16'hDEAD;
            @(negedge clk);
            start_i = 1'b0;
            chk(bus_out_o === a, "R7 bus address unchanged by busy start", bus_out_o, a);
        end
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done_o);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk({read_req_o, bus_oe_o, dev_ack_o, done_o} === 4'b0, "R1 controls low in reset",
            {12'd0, read_req_o, bus_oe_o, dev_ack_o, done_o}, 0);
        chk(data_o === '0, "R1 data zero in reset", data_o, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({read_req_o, bus_oe_o, dev_ack_o, done_o} === 4'b0, "R1 controls low after reset",
            {12'd0, read_req_o, bus_oe_o, dev_ack_o, done_o}, 0);

        issue(16'h0000, 0, "R2");
        wait_done();
        repeat (5) @(negedge clk);
        issue(16'hFFFF, 0, "R2");
        wait_done();
        repeat (2) @(negedge clk);
        issue(16'h1234, 1, "R2");
        wait_done();
        chk(read_req_o === 1'b0, "R7 no request after busy start", {15'd0, read_req_o}, 0);
        repeat (3) @(negedge clk);
        issue(16'hA5A6, 1, "R2");
        wait_done();
        // Back-to-back: start raised in the done cycle.
        issue(16'h0F0F, 0, "R2");
        wait_done();
        issue(16'h7001, 0, "R8");
        wait_done();
        issue(16'h8002, 0, "R8");
        wait_done();
        repeat (20) @(negedge clk);

        chk(n_done == issued_q.size(), "R7 completions equal accepted starts",
            W'(n_done), W'(issued_q.size()));
        chk(seen_q.size() == issued_q.size(), "R7 memory saw each request once",
            W'(seen_q.size()), W'(issued_q.size()));
        foreach (issued_q[i]) begin
            if (i < seen_q.size())
                chk(seen_q[i] === issued_q[i], "R2 address seen by memory", seen_q[i], issued_q[i]);
        end
        chk(exp_q.size() == 0, "R6 every read completed", W'(exp_q.size()), 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R6 actual=hung expected=complete");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule